// File: doc/BRIEF.md
# I2C SCL Clock Synchronizer

This block produces the serial clock for an I2C-style byte engine. The internal SCL is timed by a reloadable down-counter. Each half-period lasts the reload value plus one count cycles. The block drives the line only through an open-drain enable, so the real line is the wired-AND of every device. When synchronization is on, the block follows the real line in two ways. If another device pulls SCL low during a high phase, a new low phase starts at once with a fresh count. If a device stretches the line low after the block has released it, the high-phase count is frozen until the line comes back high.

A frame starts with a lead half-period at high level, which puts a falling edge half a period after the start request. Nine clock pulses follow. A clock-phase option adds a tenth pulse. Two hold controls can park the line low: one at the falling edge after the ninth pulse, one at the falling edge after the tenth. A force control pulls the line low at any time. A release-on-stop control returns the block to idle, with the line undriven, when an external stop detector fires. The effective transfer clock given to the shifters is the internal SCL ANDed with the synchronized line level.

The controller is a state machine with six states:
- `ST_IDLE`: released, internal SCL high.
- `ST_LEAD`: timed half-period at high level before the first fall.
- `ST_LOW`: timed low phase.
- `ST_HIGH`: timed high phase, which can freeze.
- `ST_HOLD9`: parked low after the ninth pulse.
- `ST_HOLD10`: parked low after the tenth pulse.

Its transitions are:
- start (IDLE→LEAD)
- first fall (LEAD→LOW)
- rise (LOW→HIGH)
- next fall (HIGH→LOW)
- ninth-pulse hold (HIGH→HOLD9)
- tenth-pulse hold (HIGH→HOLD10)
- frame end (HIGH→IDLE)
- hold release (HOLD9/HOLD10→IDLE)
- stop release (any state→IDLE)

Top module: `i2c_scl_sync`

## Requirements
- R1: After reset the open-drain enable is 0 and the transfer clock is 1 while the line is high. A start request sampled on a clock edge keeps the line released for exactly reload+1 cycles, and the enable then rises.
- R2: Every low phase lasts reload+1 cycles. With synchronization off, every high phase also lasts reload+1 cycles, and the line level has no effect on timing.
- R3: With synchronization on, the high-phase count advances only while both synchronizer stages read high. An undisturbed high phase therefore lasts reload+3 cycles. A high phase that another device stretches ends reload+3 cycles after that device lets go.
- R4: With synchronization on, a line fall seen during a high phase (after the line was seen high in that phase) starts a new low phase three cycles after the pin falls. That low phase has a freshly reloaded count.
- R5: With the clock-phase option at 0, a frame has 9 low pulses. With it at 1, a frame has 10. Without a hold, the line stays released after the last pulse.
- R6: With the ninth-pulse hold set, the line is driven low from the falling edge after the 9th pulse. It stays low until the control clears, and one cycle later it is released.
- R7: With the clock-phase option at 1 and the tenth-pulse hold set (ninth-pulse hold clear), the line is held low from the falling edge after the 10th pulse. It is released one cycle after the control clears. With the option at 0, the tenth-pulse hold has no effect.
- R8: The force control drives the enable to 1 in the same cycle, in any state. Clearing it returns the line to the running clock.
- R9: A stop indication with release-on-stop set brings the block to idle at the next edge, with the enable 0 unless forced. Without release-on-stop, a stop indication changes nothing.
- R10: The transfer clock is internal SCL AND the pin level after a two-flop synchronizer. A pin fall reaches it two edges later, and it is 0 in every low or hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in_i | input | 1 | Raw SCL line level |
| reload_i | input | BRG_W | Half-period reload value |
| sync_en_i | input | 1 | Follow external edges and stretching |
| start_i | input | 1 | Begin a frame when idle |
| extra_pulse_i | input | 1 | Clock-phase option: add a tenth pulse |
| hold9_en_i | input | 1 | Hold low after the ninth pulse |
| hold10_en_i | input | 1 | Hold low after the tenth pulse |
| force_low_i | input | 1 | Drive SCL low immediately |
| rel_on_stop_i | input | 1 | Release on stop indication |
| stop_det_i | input | 1 | Stop condition detected |
| scl_oe_o | output | 1 | Open-drain enable (1 = pull low) |
| xfer_clk_o | output | 1 | Effective transfer clock |

## Verification
The assertions check several rules on every cycle:
- a frozen counter stays frozen while the line is held low;
- an external fall always lands in a low phase carrying the current reload;
- a low phase never ends before its count runs out;
- a hold persists while its control is set;
- the stop release takes effect at the next edge.

Only the bench scenarios can show the exact half-period lengths as a function of reload and synchronizer latency, the pulse count per frame under each option, the length of a stretched or cut-short high phase, and the release of holds and forced lows seen at the pins.

// File: rtl/sclsync_pkg.sv
package sclsync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_HOLD9,
        ST_HOLD10
    } sclsync_state_e;

endpackage

// File: rtl/sclsync_line_mon.sv
module sclsync_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw_i,
    input  logic watch_i,
    output logic pin_s_o,
    output logic line_high_o,
    output logic ext_fall_o
);

    logic [SYNC_STAGES-1:0] sh_q;
    logic                   seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-2:0], pin_raw_i};
        end
    end

    // Line counts as high only when every stage agrees, which filters the
    // stale ones still in the pipe right after this block stops pulling low.
    assign pin_s_o     = sh_q[SYNC_STAGES-1];
    assign line_high_o = &sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= watch_i && (seen_q || line_high_o);
        end
    end

    assign ext_fall_o = watch_i && seen_q && !pin_s_o;

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall_o |-> $past(watch_i)) else $error("fall outside watched phase"); // R4

endmodule

// File: rtl/sclsync_baud.sv
module sclsync_baud #(
    parameter int BRG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BRG_W-1:0] reload_i,
    input  logic             count_en_i,
    output logic [BRG_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [BRG_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (count_en_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    AST_BAUD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o) else $error("counter wrapped"); // R2

endmodule

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync
    import sclsync_pkg::*;
#(
    parameter int BRG_W        = 8,
    parameter int FRAME_PULSES = 9,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in_i,
    input  logic [BRG_W-1:0] reload_i,
    input  logic             sync_en_i,
    input  logic             start_i,
    input  logic             extra_pulse_i,
    input  logic             hold9_en_i,
    input  logic             hold10_en_i,
    input  logic             force_low_i,
    input  logic             rel_on_stop_i,
    input  logic             stop_det_i,
    output logic             scl_oe_o,
    output logic             xfer_clk_o
);

    localparam int                PCNT_W  = $clog2(FRAME_PULSES + 2);
    localparam logic [PCNT_W-1:0] LAST_P  = PCNT_W'(FRAME_PULSES);
    localparam logic [PCNT_W-1:0] EXTRA_P = PCNT_W'(FRAME_PULSES + 1);
    localparam logic [PCNT_W-1:0] ONE_P   = PCNT_W'(1);

    sclsync_state_e    state_q, state_d;
    logic [PCNT_W-1:0] pcnt_q, pcnt_d;
    logic [BRG_W-1:0]  cnt;
    logic              zero, load, count_en, done;
    logic              pin_s, line_high, ext_fall;
    logic              hi_phase, hi_end, rel_stop, int_scl;

    assign hi_phase = (state_q == ST_LEAD) || (state_q == ST_HIGH);
    assign rel_stop = stop_det_i && rel_on_stop_i;

    sclsync_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_raw_i   (scl_in_i),
        .watch_i     (hi_phase),
        .pin_s_o     (pin_s),
        .line_high_o (line_high),
        .ext_fall_o  (ext_fall)
    );

    sclsync_baud #(.BRG_W(BRG_W)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .reload_i   (reload_i),
        .count_en_i (count_en),
        .cnt_o      (cnt),
        .zero_o     (zero)
    );

    // High phases freeze while the line is held low by someone else.
    assign count_en = (state_q == ST_LOW) || (hi_phase && (!sync_en_i || line_high));
    assign done     = count_en && zero;
    assign hi_end   = hi_phase && (done || (sync_en_i && ext_fall));

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        load    = 1'b0;
        if (rel_stop) begin
            state_d = ST_IDLE;
            pcnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_d = ST_LEAD;
                        pcnt_d  = '0;
                        load    = 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (hi_end) begin
                        state_d = ST_LOW;
                        pcnt_d  = ONE_P;
                        load    = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (done) begin
                        state_d = ST_HIGH;
                        load    = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (hi_end) begin
                        if (pcnt_q == LAST_P) begin
                            if (hold9_en_i) begin
                                state_d = ST_HOLD9;
                            end else if (extra_pulse_i) begin
                                state_d = ST_LOW;
                                pcnt_d  = EXTRA_P;
                                load    = 1'b1;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else if (pcnt_q == EXTRA_P) begin
                            state_d = hold10_en_i ? ST_HOLD10 : ST_IDLE;
                        end else begin
                            state_d = ST_LOW;
                            pcnt_d  = pcnt_q + 1'b1;
                            load    = 1'b1;
                        end
                    end
                end
                ST_HOLD9: begin
                    if (!hold9_en_i) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_HOLD10: begin
                    if (!hold10_en_i) begin
                        state_d = ST_IDLE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_LEAD, ST_HIGH: int_scl = 1'b1;
            default:                   int_scl = 1'b0;
        endcase
        scl_oe_o   = force_low_i || !int_scl;
        xfer_clk_o = int_scl && pin_s;
    end

    AST_FREEZE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_phase && sync_en_i && !line_high && !ext_fall) |=> $stable(cnt))
        else $error("count moved while line held low"); // R3

    AST_EXT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LEAD || (state_q == ST_HIGH && pcnt_q < LAST_P))
            && sync_en_i && ext_fall && !rel_stop)
        |=> (state_q == ST_LOW && cnt == $past(reload_i)))
        else $error("external fall did not reload"); // R4

    AST_LOW_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && !done && !rel_stop) |=> (state_q == ST_LOW))
        else $error("low phase cut short"); // R2

    AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= EXTRA_P) else $error("pulse count overflow"); // R5

    AST_HOLD9_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD9 && hold9_en_i && !rel_stop) |=> scl_oe_o)
        else $error("ninth-pulse hold lost"); // R6

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_stop |=> (!scl_oe_o || force_low_i))
        else $error("stop did not release line"); // R9

endmodule

// File: tb/i2c_scl_sync_test.sv
module i2c_scl_sync_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_low;
    logic [7:0] reload;
    logic       sync_en, start, ckph, h9, h10, force_low, rel, stop;
    wire        scl_oe, xfer;
    wire        scl_line = !scl_oe && !ext_low;
    int         vectors = 0;
    int         miscompares = 0;
    int         cyc = 0;

    always #5 clk = ~clk;

    i2c_scl_sync uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in_i      (scl_line),
        .reload_i      (reload),
        .sync_en_i     (sync_en),
        .start_i       (start),
        .extra_pulse_i (ckph),
        .hold9_en_i    (h9),
        .hold10_en_i   (h10),
        .force_low_i   (force_low),
        .rel_on_stop_i (rel),
        .stop_det_i    (stop),
        .scl_oe_o      (scl_oe),
        .xfer_clk_o    (xfer)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_len(input logic lvl, input int lim, output int n);
        n = 0;
        while (scl_oe === lvl && n < lim) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_frame(input int r, input bit sy, input bit ph, input bit a9, input bit a10);
        reload  = 8'(r);
        sync_en = sy;
        ckph    = ph;
        h9      = a9;
        h10     = a10;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic full_frame(input int r, input bit sy, input bit ph, input bit a9, input bit a10);
        int n, np, hexp, lim;
        bit held;
        held = a9 || (ph && a10);
        np   = a9 ? 9 : (ph ? 10 : 9);
        hexp = sy ? r + 3 : r + 1;
        lim  = 4 * (r + 4);
        start_frame(r, sy, ph, a9, a10);
        run_len(1'b0, lim, n);
        chk("R1 lead length", n, r + 1);
        for (int p = 1; p <= np; p++) begin
            run_len(1'b1, lim, n);
            chk("R2 low length", n, r + 1);
            run_len(1'b0, lim, n);
            if (p < np || held) chk(sy ? "R3 high length" : "R2 high length", n, hexp);
            else chk("R5 released after last pulse", n, lim);
        end
        if (held) begin
            run_len(1'b1, lim, n);
            chk(a9 ? "R6 hold kept" : "R7 hold kept", n, lim);
            h9  = 1'b0;
            h10 = 1'b0;
            @(negedge clk);
            chk(a9 ? "R6 hold released" : "R7 hold released", int'(scl_oe), 0);
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        int n;
        rst_n = 1'b0; ext_low = 1'b0; reload = '0; sync_en = 1'b0; start = 1'b0;
        ckph = 1'b0; h9 = 1'b0; h10 = 1'b0; force_low = 1'b0; rel = 1'b0; stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset enable", int'(scl_oe), 0);
        chk("R1 reset transfer clock", int'(xfer), 1);

        // R10: pin fall reaches transfer clock two edges later
        ext_low = 1'b1;
        @(negedge clk);
        chk("R10 one edge after fall", int'(xfer), 1);
        @(negedge clk);
        chk("R10 two edges after fall", int'(xfer), 0);
        ext_low = 1'b0;
        @(negedge clk);
        chk("R10 one edge after rise", int'(xfer), 0);
        @(negedge clk);
        chk("R10 two edges after rise", int'(xfer), 1);
        repeat (2) @(negedge clk);

        // Sweep: reload, sync, clock-phase option, hold controls (R5 R6 R7)
        for (int r = 0; r < 4; r++)
            for (int sy = 0; sy < 2; sy++)
                for (int ph = 0; ph < 2; ph++)
                    for (int m = 0; m < 4; m++)
                        full_frame(r, sy[0], ph[0], m[0], m[1]);

        // R2: sync off, line pulled low during high phase has no effect
        start_frame(3, 1'b0, 1'b0, 1'b0, 1'b0);
        run_len(1'b0, 40, n);
        run_len(1'b1, 40, n);
        ext_low = 1'b1;
        run_len(1'b0, 40, n);
        chk("R2 sync off ignores line", n, 4);
        ext_low = 1'b0;
        repeat (300) @(negedge clk);

        // R3: stretched high phase
        start_frame(2, 1'b1, 1'b0, 1'b0, 1'b0);
        run_len(1'b0, 40, n);
        run_len(1'b1, 40, n);
        ext_low = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 line held during stretch", int'(scl_oe), 0);
        ext_low = 1'b0;
        run_len(1'b0, 40, n);
        chk("R3 high after stretch", n, 5);
        repeat (300) @(negedge clk);

        // R4: external fall cuts the high phase and reloads
        start_frame(5, 1'b1, 1'b0, 1'b0, 1'b0);
        run_len(1'b0, 40, n);
        run_len(1'b1, 40, n);
        repeat (3) @(negedge clk);
        ext_low = 1'b1;
        run_len(1'b0, 40, n);
        chk("R4 cycles after external fall", n, 3);
        ext_low = 1'b0;
        run_len(1'b1, 40, n);
        chk("R4 reloaded low length", n, 6);
        repeat (300) @(negedge clk);

        // R8: force low in idle and mid-frame
        force_low = 1'b1;
        #1;
        chk("R8 idle force", int'(scl_oe), 1);
        @(negedge clk);
        force_low = 1'b0;
        #1;
        chk("R8 idle force cleared", int'(scl_oe), 0);
        start_frame(3, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        force_low = 1'b1;
        #1;
        chk("R8 force mid-frame", int'(scl_oe), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 force held", int'(scl_oe), 1);
        end
        force_low = 1'b0;
        repeat (300) @(negedge clk);
        chk("R8 frame completes after force", int'(scl_oe), 0);
        chk("R8 transfer clock idle", int'(xfer), 1);

        // R9: stop release, with and without enable
        start_frame(1, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (300) @(negedge clk);
        chk("R6 parked before stop", int'(scl_oe), 1);
        chk("R10 transfer clock low in hold", int'(xfer), 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9 stop without enable ignored", int'(scl_oe), 1);
        rel  = 1'b1;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9 stop releases line", int'(scl_oe), 0);
        h9  = 1'b0;
        rel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 idle after release", int'(scl_oe), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule